// File: doc/BRIEF.md
# Cascaded Interrupt Priority Encoder

This block gathers three groups of interrupt requests (critical, main and peripheral) and reports the winner of each group in one registered status word. It also raises a single request line towards the processor core. A second-level group of DMA event sources sits behind peripheral slot 0. That group keeps its own sticky pending register, which is cleared by writing ones, and its own mask. Each group picks its lowest-numbered live source; there are no programmable priorities.

The main, peripheral and DMA groups each have a mask register, where a set bit silences a source. Software writes the mask registers, and clears DMA pending bits, through a small write port that selects one register per write. Beside the raw status word, the block decodes the serviced source into a group code and an index. In that decode, critical code 2 and main code 4 hand service over to the peripheral field, and peripheral code 0 hands service over to the DMA group.

Top module: `irqcas_top`

## Requirements
- R1: After reset the status word and the core request are 0, the DMA pending register is empty, and the masks hold their reset values: main 0x00010FFF (indices 1 to 4 live), peripheral 0x7FFFFC00 (indices 0 and 22 to 31 live) and DMA 0xFFFFFFFF (all masked).
- R2: Any asserted critical input sets status bit 10, and bits 9:8 hold the lowest asserted critical index. Critical inputs have no mask.
- R3: Main source l is live when its input is high and main mask bit 16−l is 0. Bit 21 flags any live main source, and bits 20:16 hold the lowest live index.
- R4: Peripheral source l is live when its request is high and peripheral mask bit 31−l is 0. Bit 29 flags any live peripheral source, and bits 28:24 hold the lowest live index. Slot 0 has no input pin; its request is the DMA cascade.
- R5: A high DMA event bit sets its pending bit. A write with select 3 clears every pending bit whose data bit is 1, so 0xFFFFFFFF empties the register. When an event and a clear hit the same bit in the same cycle, the bit stays set.
- R6: DMA source l is live when it is pending and DMA mask bit l is 0. Peripheral slot 0 requests only while at least one DMA source is live; a pending but masked source does not raise it.
- R7: The DMA index output holds the lowest set bit of the pending register, whether or not that bit is masked. It reads 0 when nothing is pending.
- R8: The status word, core request and DMA index are registered. A request change sampled at clock edge k shows at edge k. A mask write or DMA event taken at edge k shows at edge k+1.
- R9: The core request is high exactly when at least one of the three group flags is set. With no flag set the status word is 0, and status bits outside the three fields are always 0.
- R10: The serviced source is decoded with this priority. Critical first: code 2 redirects, any other code gives group 0. Then main: code 4 redirects, any other code gives group 1. Then peripheral. A redirect, or the peripheral flag itself, uses the peripheral field: a field of 0 gives group 3 with the DMA index, any other value gives group 2 with the field. With no flag set, the group and index are 0.
- R11: A write with select 0 loads the main mask from data bits 16:0 and ignores the upper bits. Select 1 loads the peripheral mask and select 2 loads the DMA mask, each from the full 32 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| critIn | input | 4 | Critical request lines |
| mainIn | input | 17 | Main request lines, index 0 to 16 |
| periIn | input | 31 | Peripheral request lines, index 1 to 31 |
| dmaEvt | input | 32 | DMA event pulses that set pending bits |
| cfgWe | input | 1 | Write strobe for the configuration port |
| cfgSel | input | 2 | 0 main mask, 1 peripheral mask, 2 DMA mask, 3 pending clear |
| cfgData | input | 32 | Write data |
| statusWord | output | 32 | Encoded status word |
| irqOut | output | 1 | Request to the core |
| dmaIdx | output | 5 | Lowest pending DMA index |
| svcGroup | output | 2 | Serviced group: 0 critical, 1 main, 2 peripheral, 3 DMA |
| svcIdx | output | 5 | Serviced index within that group |

## Verification
The bench builds the block with the package defaults: 4 critical, 17 main, 32 peripheral and 32 DMA sources. These sizes fill every status field to its full width. With them the bench can reach the mask bit at the top of the main register (index 0), peripheral indices above 21 that are live only after reset, and DMA bits at both ends of the pending register. Because the sizes match the fixed status layout, the redirect codes 2 and 4 and the cascade through peripheral slot 0 can each be driven on their own and together with higher-priority groups.

// File: rtl/irqcas_pkg.sv
package irqcas_pkg;
  parameter int CRIT_N = 4;
  parameter int MAIN_N = 17;
  parameter int PERI_N = 32;
  parameter int DMA_N  = 32;
  parameter int WORD_W = 32;

  localparam int CRIT_W = $clog2(CRIT_N);
  localparam int IDX_W  = 5;

  // status word layout (fixed; software decodes these positions)
  localparam int CRIT_FLAG = 10;
  localparam int CRIT_LSB  = 8;
  localparam int MAIN_FLAG = 21;
  localparam int MAIN_LSB  = 16;
  localparam int PERI_FLAG = 29;
  localparam int PERI_LSB  = 24;

  localparam logic [WORD_W-1:0] MAIN_MASK_RST = 32'h0001_0FFF;
  localparam logic [WORD_W-1:0] PERI_MASK_RST = 32'h7FFF_FC00;
  localparam logic [WORD_W-1:0] DMA_MASK_RST  = 32'hFFFF_FFFF;

  localparam int CRIT_TO_PERI = 2;
  localparam int MAIN_TO_PERI = 4;

  typedef enum logic [1:0] {
    GRP_CRIT = 2'd0, GRP_MAIN = 2'd1, GRP_PERI = 2'd2, GRP_DMA = 2'd3
  } svc_grp_e;

  typedef enum logic [1:0] {
    SEL_MAIN_MASK = 2'd0, SEL_PERI_MASK = 2'd1, SEL_DMA_MASK = 2'd2, SEL_PEND_CLR = 2'd3
  } cfg_sel_e;

  typedef struct packed {
    logic wrMain;
    logic wrPeri;
    logic wrDma;
    logic clrPend;
  } cfg_strobe_t;

  function automatic logic [IDX_W-1:0] lowestIdx(input logic [WORD_W-1:0] v);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = WORD_W - 1; i >= 0; i--) begin
      if (v[i]) r = IDX_W'(i);
    end
    return r;
  endfunction
endpackage

// File: rtl/irqcas_ctrl.sv
module irqcas_ctrl
  import irqcas_pkg::*;
(
  input  logic        cfgWe,
  input  logic [1:0]  cfgSel,
  output cfg_strobe_t strb
);
  always_comb begin
    strb = '0;
    if (cfgWe) begin
      unique case (cfg_sel_e'(cfgSel))
        SEL_MAIN_MASK: strb.wrMain  = 1'b1;
        SEL_PERI_MASK: strb.wrPeri  = 1'b1;
        SEL_DMA_MASK:  strb.wrDma   = 1'b1;
        SEL_PEND_CLR:  strb.clrPend = 1'b1;
        default:       strb = '0;
      endcase
    end
  end
endmodule

// File: rtl/irqcas_datapath.sv
module irqcas_datapath
  import irqcas_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  cfg_strobe_t       strb,
  input  logic [WORD_W-1:0] cfgData,
  input  logic [CRIT_N-1:0] critIn,
  input  logic [MAIN_N-1:0] mainIn,
  input  logic [PERI_N-1:1] periIn,
  input  logic [DMA_N-1:0]  dmaEvt,
  output logic [WORD_W-1:0] statusQ,
  output logic              irqQ,
  output logic [IDX_W-1:0]  dmaIdxQ,
  output logic [1:0]        svcGroup,
  output logic [IDX_W-1:0]  svcIdx
);
  logic [MAIN_N-1:0] mainMask;
  logic [PERI_N-1:0] periMask;
  logic [DMA_N-1:0]  dmaMask;
  logic [DMA_N-1:0]  dmaPend;

  logic [MAIN_N-1:0] mainLive;
  logic [PERI_N-1:0] periLive;
  logic [DMA_N-1:0]  dmaLive;

  // mask registers and sticky DMA pending
  always_ff @(posedge clk) begin
    if (!rstN) begin
      mainMask <= MAIN_MASK_RST[MAIN_N-1:0];
      periMask <= PERI_MASK_RST[PERI_N-1:0];
      dmaMask  <= DMA_MASK_RST[DMA_N-1:0];
      dmaPend  <= '0;
    end else begin
      if (strb.wrMain) mainMask <= cfgData[MAIN_N-1:0];
      if (strb.wrPeri) periMask <= cfgData[PERI_N-1:0];
      if (strb.wrDma)  dmaMask  <= cfgData[DMA_N-1:0];
      dmaPend <= (dmaPend & ~(strb.clrPend ? cfgData[DMA_N-1:0] : '0)) | dmaEvt;
    end
  end

  // masks are stored with the source order reversed for main and peripheral
  for (genvar l = 0; l < MAIN_N; l++) begin : g_mainLive
    assign mainLive[l] = mainIn[l] & ~mainMask[MAIN_N-1-l];
  end

  assign dmaLive = dmaPend & ~dmaMask;

  for (genvar l = 0; l < PERI_N; l++) begin : g_periLive
    if (l == 0) begin : g_cascade
      assign periLive[l] = (|dmaLive) & ~periMask[PERI_N-1];
    end else begin : g_pin
      assign periLive[l] = periIn[l] & ~periMask[PERI_N-1-l];
    end
  end

  logic [IDX_W-1:0]  critWin, mainWin, periWin;
  logic [WORD_W-1:0] statusNext;

  always_comb begin
    critWin = lowestIdx(WORD_W'(critIn));
    mainWin = lowestIdx(WORD_W'(mainLive));
    periWin = lowestIdx(WORD_W'(periLive));
    statusNext = '0;
    if (|critIn) begin
      statusNext[CRIT_FLAG] = 1'b1;
      statusNext[CRIT_LSB +: CRIT_W] = critWin[CRIT_W-1:0];
    end
    if (|mainLive) begin
      statusNext[MAIN_FLAG] = 1'b1;
      statusNext[MAIN_LSB +: IDX_W] = mainWin;
    end
    if (|periLive) begin
      statusNext[PERI_FLAG] = 1'b1;
      statusNext[PERI_LSB +: IDX_W] = periWin;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statusQ <= '0;
      irqQ    <= 1'b0;
      dmaIdxQ <= '0;
    end else begin
      statusQ <= statusNext;
      irqQ    <= (|critIn) | (|mainLive) | (|periLive);
      dmaIdxQ <= lowestIdx(WORD_W'(dmaPend));
    end
  end

  // serviced-source decode with redirection
  logic [CRIT_W-1:0] critField;
  logic [IDX_W-1:0]  mainField, periField;
  logic              toPeri;

  always_comb begin
    critField = statusQ[CRIT_LSB +: CRIT_W];
    mainField = statusQ[MAIN_LSB +: IDX_W];
    periField = statusQ[PERI_LSB +: IDX_W];
    toPeri    = 1'b0;
    svcGroup  = GRP_CRIT;
    svcIdx    = '0;
    if (statusQ[CRIT_FLAG]) begin
      if (critField == CRIT_W'(CRIT_TO_PERI)) toPeri = 1'b1;
      else begin
        svcGroup = GRP_CRIT;
        svcIdx   = IDX_W'(critField);
      end
    end else if (statusQ[MAIN_FLAG]) begin
      if (mainField == IDX_W'(MAIN_TO_PERI)) toPeri = 1'b1;
      else begin
        svcGroup = GRP_MAIN;
        svcIdx   = mainField;
      end
    end else if (statusQ[PERI_FLAG]) begin
      toPeri = 1'b1;
    end
    if (toPeri) begin
      if (periField == '0) begin
        svcGroup = GRP_DMA;
        svcIdx   = dmaIdxQ;
      end else begin
        svcGroup = GRP_PERI;
        svcIdx   = periField;
      end
    end
  end
endmodule

// File: rtl/irqcas_top.sv
module irqcas_top
  import irqcas_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [CRIT_N-1:0] critIn,
  input  logic [MAIN_N-1:0] mainIn,
  input  logic [PERI_N-1:1] periIn,
  input  logic [DMA_N-1:0]  dmaEvt,
  input  logic              cfgWe,
  input  logic [1:0]        cfgSel,
  input  logic [WORD_W-1:0] cfgData,
  output logic [WORD_W-1:0] statusWord,
  output logic              irqOut,
  output logic [IDX_W-1:0]  dmaIdx,
  output logic [1:0]        svcGroup,
  output logic [IDX_W-1:0]  svcIdx
);
  cfg_strobe_t strb;

  irqcas_ctrl u_ctrl (
    .cfgWe (cfgWe),
    .cfgSel(cfgSel),
    .strb  (strb)
  );

  irqcas_datapath u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .cfgData (cfgData),
    .critIn  (critIn),
    .mainIn  (mainIn),
    .periIn  (periIn),
    .dmaEvt  (dmaEvt),
    .statusQ (statusWord),
    .irqQ    (irqOut),
    .dmaIdxQ (dmaIdx),
    .svcGroup(svcGroup),
    .svcIdx  (svcIdx)
  );
endmodule

// File: rtl/irqcas_chk.sv
module irqcas_chk
  import irqcas_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic [CRIT_N-1:0] critIn,
  input logic [WORD_W-1:0] statusWord,
  input logic              irqOut,
  input logic [1:0]        svcGroup
);
  localparam logic [WORD_W-1:0] USED_BITS = 32'h3F3F_0700;

  assert_crit_flag_R2: assert property (@(posedge clk) disable iff (!rstN)
    (|critIn) |=> (statusWord[CRIT_FLAG] && irqOut));

  assert_crit_lowest_R2: assert property (@(posedge clk) disable iff (!rstN)
    statusWord[CRIT_FLAG] |->
      (((($past(critIn) >> statusWord[CRIT_LSB +: CRIT_W]) & CRIT_N'(1)) != '0) &&
       (($past(critIn) & ((CRIT_N'(1) << statusWord[CRIT_LSB +: CRIT_W]) - CRIT_N'(1))) == '0)));

  assert_idle_zero_R9: assert property (@(posedge clk) disable iff (!rstN)
    !irqOut |-> (statusWord == '0));

  assert_flag_request_R9: assert property (@(posedge clk) disable iff (!rstN)
    (statusWord[CRIT_FLAG] || statusWord[MAIN_FLAG] || statusWord[PERI_FLAG]) == irqOut);

  assert_unused_bits_R9: assert property (@(posedge clk) disable iff (!rstN)
    (statusWord & ~USED_BITS) == '0);

  assert_dma_via_slot0_R10: assert property (@(posedge clk) disable iff (!rstN)
    (svcGroup == 2'(GRP_DMA)) |-> (statusWord[PERI_LSB +: IDX_W] == '0));
endmodule

bind irqcas_top irqcas_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .critIn    (critIn),
  .statusWord(statusWord),
  .irqOut    (irqOut),
  .svcGroup  (svcGroup)
);

// File: tb/irqcas_top_tb.sv
module irqcas_top_tb;
  import irqcas_pkg::*;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [CRIT_N-1:0] critIn = '0;
  logic [MAIN_N-1:0] mainIn = '0;
  logic [PERI_N-1:1] periIn = '0;
  logic [DMA_N-1:0]  dmaEvt = '0;
  logic              cfgWe = 1'b0;
  logic [1:0]        cfgSel = '0;
  logic [WORD_W-1:0] cfgData = '0;
  logic [WORD_W-1:0] statusWord;
  logic              irqOut;
  logic [IDX_W-1:0]  dmaIdx;
  logic [1:0]        svcGroup;
  logic [IDX_W-1:0]  svcIdx;

  always #2 clk = ~clk;

  irqcas_top u_dut (
    .clk(clk), .rstN(rstN), .critIn(critIn), .mainIn(mainIn), .periIn(periIn),
    .dmaEvt(dmaEvt), .cfgWe(cfgWe), .cfgSel(cfgSel), .cfgData(cfgData),
    .statusWord(statusWord), .irqOut(irqOut), .dmaIdx(dmaIdx),
    .svcGroup(svcGroup), .svcIdx(svcIdx)
  );

  typedef struct {
    string             tag;
    logic [WORD_W-1:0] st;
    logic              irq;
    logic [IDX_W-1:0]  di;
    logic [1:0]        grp;
    logic [IDX_W-1:0]  idx;
  } item_t;

  item_t sbq[$];
  int nCompared = 0;
  int nFailed = 0;
  bit finished = 1'b0;

  // reference state, kept from the requirements
  logic [MAIN_N-1:0] refMain = 17'h1_0FFF;
  logic [PERI_N-1:0] refPeri = 32'h7FFF_FC00;
  logic [DMA_N-1:0]  refDmaM = 32'hFFFF_FFFF;
  logic [DMA_N-1:0]  refPend = '0;

  function automatic item_t predict(string tag);
    item_t e;
    int c, m, p, d;
    logic dmaReq;
    logic toP;
    c = -1; m = -1; p = -1; d = -1;
    for (int l = CRIT_N - 1; l >= 0; l--) if (critIn[l]) c = l;
    for (int l = MAIN_N - 1; l >= 0; l--) if (mainIn[l] && !refMain[16 - l]) m = l;
    dmaReq = |(refPend & ~refDmaM);
    for (int l = PERI_N - 1; l >= 1; l--) if (periIn[l] && !refPeri[31 - l]) p = l;
    if (dmaReq && !refPeri[31]) p = 0;
    for (int l = DMA_N - 1; l >= 0; l--) if (refPend[l]) d = l;
    e.tag = tag;
    e.st  = '0;
    if (c >= 0) begin e.st[10] = 1'b1; e.st[9:8]   = 2'(c); end
    if (m >= 0) begin e.st[21] = 1'b1; e.st[20:16] = 5'(m); end
    if (p >= 0) begin e.st[29] = 1'b1; e.st[28:24] = 5'(p); end
    e.irq = (c >= 0) || (m >= 0) || (p >= 0);
    e.di  = (d >= 0) ? 5'(d) : 5'd0;
    e.grp = 2'd0;
    e.idx = 5'd0;
    toP = 1'b0;
    if (c >= 0) begin
      if (c == 2) toP = 1'b1; else begin e.grp = 2'd0; e.idx = 5'(c); end
    end else if (m >= 0) begin
      if (m == 4) toP = 1'b1; else begin e.grp = 2'd1; e.idx = 5'(m); end
    end else if (p >= 0) toP = 1'b1;
    if (toP) begin
      if (e.st[28:24] == 5'd0) begin e.grp = 2'd3; e.idx = e.di; end
      else begin e.grp = 2'd2; e.idx = e.st[28:24]; end
    end
    return e;
  endfunction

  // driver: one stimulus, two edges, then queue the expectation
  task automatic drive(string tag, logic [CRIT_N-1:0] c, logic [MAIN_N-1:0] m,
                       logic [PERI_N-1:1] p, logic [DMA_N-1:0] ev,
                       logic we, logic [1:0] sel, logic [WORD_W-1:0] data);
    @(negedge clk);
    critIn = c; mainIn = m; periIn = p; dmaEvt = ev;
    cfgWe = we; cfgSel = sel; cfgData = data;
    @(posedge clk);
    if (we) begin
      case (sel)
        2'd0: refMain = data[MAIN_N-1:0];
        2'd1: refPeri = data;
        2'd2: refDmaM = data;
        default: ;
      endcase
    end
    refPend = (refPend & ~((we && sel == 2'd3) ? data : '0)) | ev;
    @(negedge clk);
    dmaEvt = '0; cfgWe = 1'b0;
    @(posedge clk);
    sbq.push_back(predict(tag));
  endtask

  // monitor: compare away from the active edge
  initial begin
    forever begin
      @(negedge clk);
      if (sbq.size() > 0) begin
        item_t e;
        e = sbq.pop_front();
        nCompared++;
        if (statusWord !== e.st || irqOut !== e.irq || dmaIdx !== e.di ||
            svcGroup !== e.grp || svcIdx !== e.idx) begin
          nFailed++;
          $display("FAIL %s: actual st=%h irq=%b di=%0d grp=%0d idx=%0d expected st=%h irq=%b di=%0d grp=%0d idx=%0d",
                   e.tag, statusWord, irqOut, dmaIdx, svcGroup, svcIdx,
                   e.st, e.irq, e.di, e.grp, e.idx);
        end
      end
    end
  end

  task automatic directCheck(string tag, logic [WORD_W-1:0] act, logic [WORD_W-1:0] exp);
    nCompared++;
    if (act !== exp) begin
      nFailed++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nFailed++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCompared, nFailed);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    directCheck("R1 status in reset", statusWord, 32'h0);
    rstN = 1'b1;

    drive("R1 R9 idle after reset", '0, '0, '0, '0, 1'b0, 2'd0, '0);
    drive("R1 main reset mask", '0, '1, '0, '0, 1'b0, 2'd0, '0);
    drive("R1 peripheral reset mask", '0, '0, '1, '0, 1'b0, 2'd0, '0);
    drive("R6 R7 masked dma pending", '0, '0, '0, 32'h0000_0020, 1'b0, 2'd0, '0);
    drive("R2 critical lowest", 4'b1010, '1, '0, '0, 1'b0, 2'd0, '0);
    drive("R10 critical 2 redirect", 4'b0100, '0, 31'(32'h0200_0000 >> 1), '0, 1'b0, 2'd0, '0);
    drive("R11 R3 main mask cleared", '0, 17'h0_0081, '0, '0, 1'b1, 2'd0, 32'h0);
    drive("R3 main mask bit 16", '0, 17'h0_0081, '0, '0, 1'b1, 2'd0, 32'h0001_0000);
    drive("R10 main 4 redirect", '0, 17'h0_0010, 31'(32'h4000_0000 >> 1), '0, 1'b0, 2'd0, '0);
    drive("R11 R4 peripheral mask cleared", '0, '0, 31'(32'h8 >> 1), '0, 1'b1, 2'd1, 32'h0);
    drive("R6 R10 dma unmasked cascade", '0, '0, 31'(32'h8 >> 1), 32'h0000_0200, 1'b1, 2'd2, ~32'h0000_0200);
    drive("R5 write one clears", '0, '0, '0, '0, 1'b1, 2'd3, 32'h0000_0020);
    drive("R5 set beats clear", '0, '0, '0, 32'h0000_0200, 1'b1, 2'd3, 32'h0000_0200);
    drive("R5 R7 clear all", '0, '0, '0, '0, 1'b1, 2'd3, 32'hFFFF_FFFF);
    drive("R4 peripheral mask bit", '0, '0, 31'(32'h28 >> 1), '0, 1'b1, 2'd1, 32'h1000_0000);
    drive("R7 dma top bit", '0, '0, '0, 32'h8000_0000, 1'b0, 2'd0, '0);
    drive("R11 main upper data ignored", '0, 17'h0_0001, '0, '0, 1'b1, 2'd0, 32'hFFFE_0000);
    drive("R9 idle again", '0, '0, '0, '0, 1'b1, 2'd3, 32'hFFFF_FFFF);

    // R8: a request change shows only after the next edge
    @(negedge clk);
    critIn = 4'b0001;
    #1;
    directCheck("R8 before edge", statusWord, 32'h0);
    @(negedge clk);
    directCheck("R8 after edge", statusWord, 32'h0000_0400);
    critIn = '0;
    @(negedge clk);

    wait (sbq.size() == 0);
    @(negedge clk);
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCompared, nFailed);
    $finish;
  end
endmodule